// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns one host request into one read or write cycle on an external memory bus that is selected by a chip enable. It drives the active-low chip enable, output enable and write enable strobes, the address, and the data bus with its output enable. It captures read data and returns it with a one-clock completion pulse. A request is a single-clock pulse. Requests that arrive while a cycle is running are dropped.

The bus has one acknowledge/ready line, split here into an input, an output value and a drive enable. A static/dynamic setting and the per-access mode decide which way the line points. In the two internal-wait modes (normal and page), the controller counts programmed wait clocks and then pulses the line low for one clock. This pulse tells the device when data is sampled or written. In the two device-paced modes (external acknowledge and ready), the controller releases the line and waits for the device to signal on it. A strobe-hold setting adds extra clocks at the end of every access while chip enable stays low.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: Under reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, `bus_dq_oe` and `host_done` are low, and `ack_o` is high. `ack_oe` equals the inverse of `cfg_static`.
- R2: While `cfg_static` is 1, `ack_oe` is 0 in every cycle, whatever the mode.
- R3: In dynamic control with mode 0 (normal) or 1 (page), `ack_oe` stays 1. `ack_o` is low for exactly one clock, and that clock is cycle W+2 of chip enable low, where W is `cfg_wait`. `ack_i` has no effect in these modes.
- R4: In dynamic control with mode 2 (external acknowledge) or 3 (ready), `ack_oe` drops in the first cycle of chip enable low. It rises again two cycles after the last chip-enable-low cycle, that is, one clock after chip enable deasserts.
- R5: In mode 2 the wait phase ends at the first clock edge where `ack_i` is sampled 0. In mode 3 it ends where `ack_i` is sampled 1. In both modes `cfg_wait` is ignored. If the device signals in the cycle L after chip enable falls (L counted from 0), then cycle L is the strobe cycle.
- R6: On a read, `host_rdata` holds the value that `bus_dq_i` had during the strobe cycle. The strobe cycle is the acknowledge pulse cycle in modes 0 and 1, and cycle L in modes 2 and 3.
- R7: On a read, `bus_oe_n` is low exactly while `bus_ce_n` is low, and `bus_we_n` stays high.
- R8: On a write, the following hold:
  - `bus_we_n` is low from the first chip-enable-low cycle through the cycle after the strobe cycle.
  - `bus_dq_oe` is high, with `bus_dq_o` equal to the host write data, for every chip-enable-low cycle. This includes one more cycle after `bus_we_n` rises.
  - `bus_oe_n` stays high.
- R9: `cfg_hold` = H extends chip enable low by H cycles after the strobe and data phase. A read keeps chip enable low for S+H+1 cycles and a write for S+H+3 cycles, where S is the strobe-cycle index.
- R10: `host_done` is high for exactly one clock, the first cycle with chip enable high after an access. A new request may be given in that same cycle.
- R11: A `host_req` raised while an access is running is ignored, and no second cycle follows. `bus_addr` holds the accepted address for the whole access.
- R12: Page mode (1) produces the same single-beat timing as normal mode (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_static | input | 1 | 1: acknowledge line is always an input |
| cfg_mode | input | 2 | 0 normal, 1 page, 2 external acknowledge, 3 ready |
| cfg_wait | input | WAIT_W | Internal wait clocks before the acknowledge pulse |
| cfg_hold | input | HOLD_W | Extra chip-enable hold clocks |
| host_req | input | 1 | One-clock access request |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | AW | Access address |
| host_wdata | input | DW | Write data |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | DW | Captured read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Bus address |
| bus_dq_o | output | DW | Bus write data |
| bus_dq_i | input | DW | Bus read data |
| bus_dq_oe | output | 1 | Data bus drive enable |
| ack_o | output | 1 | Acknowledge value when driven |
| ack_i | input | 1 | Acknowledge/ready value from the pin |
| ack_oe | output | 1 | Acknowledge line drive enable |

## Verification
A sequencer that sits in the wrong phase shows up within one clock as a strobe edge that is misplaced relative to the acknowledge pulse. It can also show up as a chip-enable window that is too long or too short. A wrong latched mode shows up in the first access cycle, because it flips the acknowledge drive enable. A miscounted wait or hold counter moves the acknowledge pulse or the chip enable rising edge by whole cycles. A capture on the wrong edge returns the data of a neighbouring cycle, because the bench changes the read data every cycle. Each cycle is compared against a model driven by the same device timing, so any of these errors is reported in the cycle where it first appears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'd0,
    XM_PAGE   = 2'd1,
    XM_EXTACK = 2'd2,
    XM_READY  = 2'd3
  } xmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_TAIL,
    ST_DHOLD,
    ST_HOLD
  } xstate_e;

  function automatic logic dev_paced(input xmode_e m);
    return (m == XM_EXTACK) || (m == XM_READY);
  endfunction
endpackage

// File: rtl/xbus_cnt.sv
module xbus_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic          is_zero,
  output logic          is_one
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= ld_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == CW'(1));

  // R3 / R9: the sequencer never asks for a decrement below zero
  assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/xbus_ackpin.sv
module xbus_ackpin (
  input  logic clk,
  input  logic rst,
  input  logic static_i,
  input  logic rel_d,
  input  logic low_d,
  output logic ack_o,
  output logic ack_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_oe <= !static_i;
      ack_o  <= 1'b1;
    end else begin
      ack_oe <= !static_i && !rel_d;
      ack_o  <= !(low_d && !static_i);
    end
  end

  assert_ack_pulse_one_R3: assert property (@(posedge clk) disable iff (rst)
    !ack_o |=> ack_o);
  assert_ack_low_driven_R3: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> ack_oe);
  assert_static_input_R2: assert property (@(posedge clk) disable iff (rst)
    $past(static_i) |-> !ack_oe);
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      dq_o   <= '0;
      rdata  <= '0;
    end else begin
      if (accept) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (capture) rdata <= dq_i;
    end
  end
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_static,
  input  logic [1:0]        cfg_mode,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_done,
  output logic [DW-1:0]     host_rdata,
  output logic              bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dq_o,
  input  logic [DW-1:0]     bus_dq_i,
  output logic              bus_dq_oe,
  output logic              ack_o,
  input  logic              ack_i,
  output logic              ack_oe
);
  import xbus_pkg::*;

  localparam int CW = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  xstate_e           st, st_d;
  xmode_e            ctx_mode;
  logic              ctx_we;
  logic [HOLD_W-1:0] ctx_hold;

  logic          accept, ext_c, hit, strobe_end, capture;
  logic          cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic [CW-1:0] cnt_val;
  logic          nxt_we, nxt_ext, busy_d, rel_d, low_d;
  xstate_e       post_st;

  assign accept     = (st == ST_IDLE) && host_req;
  assign ext_c      = dev_paced(ctx_mode);
  assign hit        = (ctx_mode == XM_EXTACK) ? !ack_i : ack_i;
  assign strobe_end = (st == ST_ACK) || (st == ST_WAIT && ext_c && hit);
  assign capture    = strobe_end && !ctx_we;
  assign post_st    = ctx_we ? ST_TAIL : ((ctx_hold == '0) ? ST_IDLE : ST_HOLD);

  always_comb begin
    st_d     = st;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    case (st)
      ST_IDLE: if (host_req) begin
        st_d     = ST_WAIT;
        cnt_load = 1'b1;
        cnt_val  = CW'(cfg_wait);
      end
      ST_WAIT: begin
        if (ext_c) begin
          if (hit) st_d = post_st;
        end else if (cnt_zero) begin
          st_d = ST_ACK;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_ACK:   st_d = post_st;
      ST_TAIL:  st_d = ST_DHOLD;
      ST_DHOLD: st_d = (ctx_hold == '0) ? ST_IDLE : ST_HOLD;
      ST_HOLD: begin
        if (cnt_one) st_d = ST_IDLE;
        else         cnt_dec = 1'b1;
      end
      default:  st_d = ST_IDLE;
    endcase
    if (st_d == ST_HOLD && st != ST_HOLD) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(ctx_hold);
    end
  end

  assign nxt_we  = accept ? host_we : ctx_we;
  assign nxt_ext = accept ? dev_paced(xmode_e'(cfg_mode)) : ext_c;
  assign busy_d  = (st_d != ST_IDLE);
  assign rel_d   = (busy_d && nxt_ext) || (!bus_ce_n && ext_c);
  assign low_d   = (st_d == ST_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ctx_mode  <= XM_NORMAL;
      ctx_we    <= 1'b0;
      ctx_hold  <= '0;
      bus_ce_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_dq_oe <= 1'b0;
      host_done <= 1'b0;
    end else begin
      st <= st_d;
      if (accept) begin
        ctx_mode <= xmode_e'(cfg_mode);
        ctx_we   <= host_we;
        ctx_hold <= cfg_hold;
      end
      bus_ce_n  <= !busy_d;
      bus_oe_n  <= !(busy_d && !nxt_we);
      bus_we_n  <= !(nxt_we && (st_d == ST_WAIT || st_d == ST_ACK || st_d == ST_TAIL));
      bus_dq_oe <= busy_d && nxt_we;
      host_done <= !busy_d && (st != ST_IDLE);
    end
  end

  xbus_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .ld_val(cnt_val), .dec(cnt_dec),
    .is_zero(cnt_zero), .is_one(cnt_one)
  );

  xbus_ackpin u_ack (
    .clk(clk), .rst(rst), .static_i(cfg_static), .rel_d(rel_d), .low_d(low_d),
    .ack_o(ack_o), .ack_oe(ack_oe)
  );

  xbus_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .addr_i(host_addr), .wdata_i(host_wdata),
    .capture(capture), .dq_i(bus_dq_i), .addr_o(bus_addr), .dq_o(bus_dq_o),
    .rdata(host_rdata)
  );

  assert_oe_within_ce_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !bus_ce_n);
  assert_no_dual_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));
  assert_dq_within_ce_R8: assert property (@(posedge clk) disable iff (rst)
    bus_dq_oe |-> !bus_ce_n);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);
  assert_done_after_ce_R10: assert property (@(posedge clk) disable iff (rst)
    host_done |-> (bus_ce_n && !$past(bus_ce_n)));
  assert_ack_released_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && ext_c) |-> !ack_oe);
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && !$past(bus_ce_n)) |-> $stable(bus_addr));
endmodule

// File: tb/xbus_cycle_ctrl_test.sv
module xbus_cycle_ctrl_test;
  localparam int AW = 16, DW = 16, WW = 4, HW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, cfg_static, host_req, host_we, ack_i;
  logic [1:0]    cfg_mode;
  logic [WW-1:0] cfg_wait;
  logic [HW-1:0] cfg_hold;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, bus_dq_i;
  logic          host_done, bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe, ack_o, ack_oe;
  logic [DW-1:0] host_rdata, bus_dq_o;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0, pat = 0;

  xbus_cycle_ctrl #(.AW(AW), .DW(DW), .WAIT_W(WW), .HOLD_W(HW)) uut (
    .clk(clk), .rst(rst), .cfg_static(cfg_static), .cfg_mode(cfg_mode),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
    .host_rdata(host_rdata), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dq_o(bus_dq_o),
    .bus_dq_i(bus_dq_i), .bus_dq_oe(bus_dq_oe), .ack_o(ack_o), .ack_i(ack_i),
    .ack_oe(ack_oe)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_chk(input int n, input string rq);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(rq, "ce_n idle", bus_ce_n, 1);
      chk(rq, "oe_n idle", bus_oe_n, 1);
      chk(rq, "we_n idle", bus_we_n, 1);
      chk(rq, "dq_oe idle", bus_dq_oe, 0);
      chk(rq, "done idle", host_done, 0);
      chk(rq, "ack_oe idle", ack_oe, !cfg_static);
      if (ack_oe) chk(rq, "ack_o idle", ack_o, 1);
    end
  endtask

  // Model: expected bus waveform of one access, indexed by cycle i after chip enable falls
  task automatic access(input logic we, input logic [1:0] mode, input int w, input int h,
                        input int lat, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit chain, input bit poke, input bit noisy);
    int s, e;
    bit ext;
    logic act_lvl;
    logic [DW-1:0] exp_rd, v;
    string ct;
    ext     = mode[1];
    act_lvl = (mode == 2'd3);
    s = ext ? lat : w + 1;
    e = we ? s + 2 + h : s + h;
    ct = (mode == 2'd1) ? "R12" : (ext ? "R5" : "R9");
    exp_rd = '0;
    cfg_mode = mode; cfg_wait = WW'(w); cfg_hold = HW'(h);
    host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
    ack_i = ext ? !act_lvl : 1'b1;
    for (int i = 0; i <= e + 2; i++) begin
      if (i == e + 2 && chain) break;
      @(negedge clk);
      host_req = poke && (i == 1);
      chk(ct, "ce_n", bus_ce_n, (i <= e) ? 0 : 1);
      chk("R7", "oe_n", bus_oe_n, (!we && i <= e) ? 0 : 1);
      chk("R8", "we_n", bus_we_n, (we && i <= s + 1) ? 0 : 1);
      chk("R8", "dq_oe", bus_dq_oe, (we && i <= e) ? 1 : 0);
      chk("R10", "done", host_done, (i == e + 1) ? 1 : 0);
      if (cfg_static) chk("R2", "ack_oe", ack_oe, 0);
      else if (ext)   chk("R4", "ack_oe", ack_oe, (i <= e + 1) ? 0 : 1);
      else            chk("R3", "ack_oe", ack_oe, 1);
      if (!cfg_static && !ext) chk("R3", "ack_o", ack_o, (i == s) ? 0 : 1);
      if (i <= e) chk("R11", "addr", bus_addr, a);
      if (we && i <= e) chk("R8", "dq_o", bus_dq_o, d);
      if (i == e + 1 && !we) chk("R6", "rdata", host_rdata, exp_rd);
      pat++;
      v = DW'(16'hA53C ^ (pat * 16'h0137));
      bus_dq_i = v;
      if (i == s) exp_rd = v;
      if (ext)        ack_i = (i == lat) ? act_lvl : !act_lvl;
      else if (noisy) ack_i = i[0];
      else            ack_i = 1'b1;
    end
    host_req = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; cfg_static = 0; cfg_mode = 0; cfg_wait = 0; cfg_hold = 0;
    host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0; ack_i = 1; bus_dq_i = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "ce_n rst", bus_ce_n, 1);
    chk("R1", "oe_n rst", bus_oe_n, 1);
    chk("R1", "we_n rst", bus_we_n, 1);
    chk("R1", "dq_oe rst", bus_dq_oe, 0);
    chk("R1", "done rst", host_done, 0);
    chk("R1", "ack_oe rst dyn", ack_oe, 1);
    chk("R1", "ack_o rst", ack_o, 1);
    rst = 0;
    idle_chk(2, "R1");
    // internal-wait modes, dynamic control
    access(0, 2'd0, 2, 0, 0, 16'h1234, 16'h0, 0, 0, 0);
    idle_chk(1, "R10");
    access(1, 2'd0, 2, 0, 0, 16'h2345, 16'hBEEF, 0, 0, 0);
    idle_chk(1, "R10");
    access(0, 2'd1, 0, 1, 0, 16'h3456, 16'h0, 0, 0, 1);
    access(1, 2'd1, 3, 2, 0, 16'h4567, 16'hC0DE, 0, 0, 1);
    // device-paced modes, wait count ignored
    access(0, 2'd2, 5, 0, 3, 16'h5678, 16'h0, 0, 0, 0);
    access(1, 2'd3, 7, 1, 0, 16'h6789, 16'h1357, 0, 0, 0);
    access(0, 2'd3, 1, 3, 4, 16'h789A, 16'h0, 0, 0, 0);
    // back-to-back: next request in the done cycle
    access(0, 2'd0, 1, 0, 0, 16'h89AB, 16'h0, 1, 0, 0);
    access(1, 2'd2, 0, 0, 2, 16'h9ABC, 16'h2468, 1, 0, 0);
    access(0, 2'd1, 0, 0, 0, 16'hABCD, 16'h0, 0, 0, 0);
    // request during a running access is dropped
    access(1, 2'd0, 2, 1, 0, 16'hBCDE, 16'hFACE, 0, 1, 0);
    idle_chk(4, "R11");
    // static control
    cfg_static = 1;
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "ack_oe rst static", ack_oe, 0);
    rst = 0;
    idle_chk(1, "R2");
    access(0, 2'd2, 0, 0, 2, 16'hCDEF, 16'h0, 0, 0, 0);
    access(1, 2'd0, 1, 0, 0, 16'hDEF0, 16'h8765, 0, 0, 0);
    idle_chk(2, "R2");
    finish_run();
  end
endmodule